// File: doc/BRIEF.md
# Throttle Alert Pulse Generator

This block turns seven throttle-request conditions into one active-low alert for a processor. Five of the conditions are level flags from comparators: an independent comparator, critical input current, nominal input current, battery discharge current and low system voltage. The other two are presence signals that count only at an edge. The battery-present signal counts when it rises. The adapter-OK signal counts when it falls. A 7-bit mask selects which conditions may raise the alert. While no adapter is attached, the four adapter-related conditions are masked off in hardware.

Once the alert is raised, it stays low for a programmable minimum width. It then stays low for as long as any enabled level condition remains true. In hold mode the alert stays low after a trigger until the host issues a clear. The low-system-voltage flag passes through a fixed deglitch window before it counts. All times are counted in a 1 µs tick, which an internal prescaler derives from the system clock.

Top module: `throttle_alert`

## Requirements
- R1: After a synchronous reset, `alert_n` is 1 and `alert_busy` is 0. Battery-present or adapter-OK levels that are present during reset do not fire an edge event when reset is released.
- R2: Bits of `evt_raw` and `evt_mask` map as follows: bit 6 comparator, bit 5 critical current, bit 4 nominal current, bit 3 discharge current, bit 2 low system voltage, bit 1 battery-present, bit 0 adapter-OK. An event whose mask bit is 0 has no effect. With the mask all zero the alert never asserts.
- R3: While `adp_present` is 0, mask bits 5, 4, 1 and 0 act as 0. Bits 6, 3 and 2 keep their programmed values.
- R4: Battery-present (bit 1) triggers once on its 0-to-1 transition. Adapter-OK (bit 0) triggers once on its 1-to-0 transition. A steady level on either input does not trigger, and neither does the opposite transition.
- R5: A trigger drives `alert_n` low on the next clock. The minimum width is sampled from `width_sel` at the trigger: 00 gives W00_US ticks (default 100), 01 gives W01_US (1000), 10 gives W10_US (12000) and 11 gives W11_US (6000).
- R6: With hold mode off, the alert releases on the first clock after the minimum width has elapsed in which no enabled level event is active. An edge event that arrives while the alert is low does not restart the width.
- R7: The low-system-voltage flag counts only after it has been high for VSYS_DGL_US consecutive ticks (default 20). Dropping the flag restarts the deglitch window.
- R8: When `hold_mode` is 1 at the trigger, the alert stays low until a one-cycle `host_clr` pulse, which releases it on the next clock. When the alert was raised with hold mode off, `host_clr` is ignored.
- R9: If an enabled event is present in the same cycle as a clear of a held alert, the alert stays low and a new pulse starts with a reloaded width.
- R10: `alert_busy` is always the inverse of `alert_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_raw | input | 7 | Event inputs, bit map as in R2 |
| adp_present | input | 1 | Adapter attached |
| evt_mask | input | 7 | Per-event enable mask |
| width_sel | input | 2 | Minimum pulse width code |
| hold_mode | input | 1 | Latch the alert until host clear |
| host_clr | input | 1 | One-cycle pulse: host writes 0 to the clear bit |
| alert_n | output | 1 | Active-low alert (open-drain enable) |
| alert_busy | output | 1 | Status: alert asserted |

## Verification
Two actions can fall in the same cycle: a host clear of a held alert and a new enabled event. The bench provokes this by pulsing `host_clr` while the comparator flag is high during hold mode. It judges the outcome against its cycle model, in which the trigger wins and the width reloads. A second overlap occurs when the minimum width expires while a level event is still active. The bench holds that event across the expiry and expects release on the first clock after the event drops.

// File: rtl/throttle_alert.sv
module throttle_alert #(
  parameter int CLKS_PER_US = 100,
  parameter int W00_US      = 100,
  parameter int W01_US      = 1000,
  parameter int W10_US      = 12000,
  parameter int W11_US      = 6000,
  parameter int VSYS_DGL_US = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] evt_raw,
  input  logic       adp_present,
  input  logic [6:0] evt_mask,
  input  logic [1:0] width_sel,
  input  logic       hold_mode,
  input  logic       host_clr,
  output logic       alert_n,
  output logic       alert_busy
);
  localparam int WMA  = (W00_US > W01_US) ? W00_US : W01_US;
  localparam int WMB  = (W10_US > W11_US) ? W10_US : W11_US;
  localparam int WMAX = (WMA > WMB) ? WMA : WMB;
  localparam int WCW  = $clog2(WMAX + 1);
  localparam int PCW  = $clog2(CLKS_PER_US + 1);
  localparam int DCW  = $clog2(VSYS_DGL_US + 1);
  localparam logic [6:0] NO_ADP_KEEP = 7'b100_1100;

  logic [PCW-1:0] pre_q;
  logic [DCW-1:0] dgl_q;
  logic [WCW-1:0] wcnt_q, w_load;
  logic           bp_q, ao_q, on_q, hold_q;
  logic           tick, vsys_ok, lvl_any, shot_any, hit, clr_ok;
  logic [6:0]     eff_mask, live;

  assign tick     = pre_q == PCW'(CLKS_PER_US - 1);
  assign vsys_ok  = evt_raw[2] && (dgl_q == DCW'(VSYS_DGL_US));
  assign eff_mask = evt_mask & (adp_present ? 7'h7F : NO_ADP_KEEP);
  assign live     = eff_mask & {evt_raw[6:3], vsys_ok,
                                evt_raw[1] & ~bp_q, ~evt_raw[0] & ao_q};
  assign lvl_any  = |live[6:2];
  assign shot_any = |live[1:0];
  assign hit      = lvl_any | shot_any;
  assign clr_ok   = host_clr & hold_q;

  always_comb begin
    case (width_sel)
      2'b00:   w_load = WCW'(W00_US);
      2'b01:   w_load = WCW'(W01_US);
      2'b10:   w_load = WCW'(W10_US);
      default: w_load = WCW'(W11_US);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      dgl_q  <= '0;
      bp_q   <= evt_raw[1];
      ao_q   <= evt_raw[0];
      on_q   <= 1'b0;
      hold_q <= 1'b0;
      wcnt_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (!evt_raw[2])
        dgl_q <= '0;
      else if (tick && dgl_q != DCW'(VSYS_DGL_US))
        dgl_q <= dgl_q + 1'b1;
      bp_q <= evt_raw[1];
      ao_q <= evt_raw[0];
      if ((!on_q || clr_ok) && hit) begin
        on_q   <= 1'b1;
        hold_q <= hold_mode;
        wcnt_q <= w_load;
      end else if (clr_ok) begin
        on_q   <= 1'b0;
        hold_q <= 1'b0;
      end else if (wcnt_q != '0) begin
        if (tick) wcnt_q <= wcnt_q - 1'b1;
      end else if (!hold_q && !lvl_any) begin
        on_q <= 1'b0;
      end
    end
  end

  assign alert_n    = ~on_q;
  assign alert_busy = on_q;
endmodule

module throttle_alert_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] evt_raw,
  input logic [6:0] evt_mask,
  input logic       adp_present,
  input logic       host_clr,
  input logic       alert_n,
  input logic       alert_busy,
  input logic       hold_q,
  input logic       hit
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= !rst_n;

  always @(posedge clk) if (rst_d) AST_RESET_RELEASED: assert (alert_n); // R1

  AST_MASK_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_mask == 7'd0 && alert_n) |=> alert_n); // R2

  AST_NO_ADP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!adp_present && alert_n && !evt_raw[6] && !evt_raw[3] && !evt_raw[2]) |=> alert_n); // R3

  AST_CMP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_n && evt_raw[6] && evt_mask[6]) |=> !alert_n); // R5

  AST_LEVEL_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_n && evt_raw[6] && evt_mask[6]) |=> !alert_n); // R6

  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && host_clr && !hit) |=> alert_n); // R8

  AST_CLEAR_TRIG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && host_clr && hit) |=> !alert_n); // R9

  AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    alert_busy == !alert_n); // R10
endmodule

bind throttle_alert throttle_alert_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_raw(evt_raw), .evt_mask(evt_mask),
  .adp_present(adp_present), .host_clr(host_clr), .alert_n(alert_n),
  .alert_busy(alert_busy), .hold_q(hold_q), .hit(hit)
);

// File: tb/test_throttle_alert.sv
module test_throttle_alert;
  localparam int P = 2, W0 = 4, W1 = 7, W2 = 12, W3 = 9, DGL = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [6:0] evt_raw = 7'b000_0011;
  logic       adp_present = 1'b1;
  logic [6:0] evt_mask = 7'h7F;
  logic [1:0] width_sel = 2'b10;
  logic       hold_mode = 1'b0;
  logic       host_clr = 1'b0;
  logic       alert_n, alert_busy;

  throttle_alert #(.CLKS_PER_US(P), .W00_US(W0), .W01_US(W1), .W10_US(W2),
                   .W11_US(W3), .VSYS_DGL_US(DGL)) i_throttle_alert (
    .clk(clk), .rst_n(rst_n), .evt_raw(evt_raw), .adp_present(adp_present),
    .evt_mask(evt_mask), .width_sel(width_sel), .hold_mode(hold_mode),
    .host_clr(host_clr), .alert_n(alert_n), .alert_busy(alert_busy));

  int vectors = 0, miscompares = 0, cycles = 0;
  string cur_req = "R1";

  // behavioural reference state
  int  m_pc, m_dc, m_wc;
  bit  m_bq, m_aq, m_al, m_la;

  function automatic int width_of(input logic [1:0] s);
    case (s)
      2'b00: return W0;
      2'b01: return W1;
      2'b10: return W2;
      default: return W3;
    endcase
  endfunction

  always @(posedge clk) begin
    bit tick, vok, lv, os, hit, clr;
    logic [6:0] em;
    if (!rst_n) begin
      m_pc = 0; m_dc = 0; m_wc = 0; m_al = 0; m_la = 0;
      m_bq = evt_raw[1]; m_aq = evt_raw[0];
    end else begin
      tick = (m_pc == P - 1);
      vok  = evt_raw[2] && (m_dc >= DGL);
      em   = adp_present ? evt_mask : (evt_mask & 7'h4C);
      lv   = (em[6] && evt_raw[6]) || (em[5] && evt_raw[5]) || (em[4] && evt_raw[4]) ||
             (em[3] && evt_raw[3]) || (em[2] && vok);
      os   = (em[1] && evt_raw[1] && !m_bq) || (em[0] && !evt_raw[0] && m_aq);
      hit  = lv || os;
      clr  = host_clr && m_al && m_la;
      if (!m_al || clr) begin
        if (hit) begin m_al = 1; m_la = hold_mode; m_wc = width_of(width_sel); end
        else begin m_al = 0; m_la = 0; end
      end else if (m_wc > 0) begin
        if (tick) m_wc--;
      end else if (!m_la && !lv) m_al = 0;
      if (!evt_raw[2]) m_dc = 0;
      else if (tick && m_dc < DGL) m_dc++;
      m_pc = tick ? 0 : m_pc + 1;
      m_bq = evt_raw[1]; m_aq = evt_raw[0];
    end
  end

  always @(negedge clk) begin
    cycles++;
    vectors++;
    if (alert_n !== !m_al) begin
      miscompares++;
      $display("FAIL %s: alert_n actual %b expected %b at cycle %0d", cur_req, alert_n, !m_al, cycles);
    end
    if (alert_busy !== m_al) begin
      miscompares++;
      $display("FAIL R10 (%s): alert_busy actual %b expected %b at cycle %0d", cur_req, alert_busy, m_al, cycles);
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_bit(input int b, input int len);
    @(negedge clk); evt_raw[b] = ~evt_raw[b];
    wait_n(len);    evt_raw[b] = ~evt_raw[b];
  endtask

  initial begin
    wait_n(4); rst_n = 1'b1;
    cur_req = "R1"; wait_n(20);
    cur_req = "R5";
    for (int s = 0; s < 4; s++) begin
      width_sel = 2'(s); pulse_bit(6, 1); wait_n(40);
    end
    width_sel = 2'b00;
    cur_req = "R6"; pulse_bit(6, 30); wait_n(20);
    pulse_bit(4, 3); wait_n(2); evt_raw[1] = 1'b0; wait_n(1); evt_raw[1] = 1'b1; wait_n(20);
    cur_req = "R4";
    evt_raw[1] = 1'b0; wait_n(15); evt_raw[1] = 1'b1; wait_n(20);
    evt_raw[0] = 1'b0; wait_n(20); evt_raw[0] = 1'b1; wait_n(20);
    cur_req = "R2";
    evt_mask = 7'b010_0000; pulse_bit(6, 3); wait_n(10); pulse_bit(5, 1); wait_n(20);
    evt_mask = 7'h00; evt_raw[6:2] = 5'h1F; wait_n(20); evt_raw[6:2] = 5'h00; wait_n(5);
    cur_req = "R3";
    evt_mask = 7'h7F; adp_present = 1'b0;
    pulse_bit(5, 2); wait_n(5); pulse_bit(4, 2); wait_n(5);
    evt_raw[1] = 1'b0; wait_n(3); evt_raw[1] = 1'b1; wait_n(3);
    evt_raw[0] = 1'b0; wait_n(3); evt_raw[0] = 1'b1; wait_n(10);
    pulse_bit(3, 1); wait_n(20); adp_present = 1'b1;
    cur_req = "R7";
    pulse_bit(2, 3); wait_n(4); pulse_bit(2, 4); wait_n(10); pulse_bit(2, 12); wait_n(25);
    cur_req = "R8";
    hold_mode = 1'b1; pulse_bit(6, 1); wait_n(50);
    host_clr = 1'b1; wait_n(1); host_clr = 1'b0; wait_n(10);
    hold_mode = 1'b0; pulse_bit(6, 1); wait_n(2);
    host_clr = 1'b1; wait_n(1); host_clr = 1'b0; wait_n(20);
    cur_req = "R9";
    hold_mode = 1'b1; pulse_bit(6, 1); wait_n(30);
    hold_mode = 1'b0; evt_raw[6] = 1'b1; host_clr = 1'b1; wait_n(1);
    host_clr = 1'b0; evt_raw[6] = 1'b0; wait_n(30);
    hold_mode = 1'b1; pulse_bit(6, 1); wait_n(5);
    host_clr = 1'b1; wait_n(1); host_clr = 1'b0; hold_mode = 1'b0; wait_n(10);
    cur_req = "R1";
    evt_raw[1] = 1'b0; evt_raw[0] = 1'b1; rst_n = 1'b0; wait_n(3);
    evt_raw[1] = 1'b1; evt_raw[0] = 1'b0; wait_n(2); rst_n = 1'b1; wait_n(20);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    miscompares++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule